// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog

A free-running up-counter shared by four compare channels. Each time a counting tick moves the counter onto a channel's compare value, that channel records an event and raises its own interrupt line, provided the channel is enabled. Software clears events by writing ones to the event register. Channel 3 doubles as a watchdog: once watchdog mode is armed, a channel 3 hit raises a reset request that stays high until the system reset.

Software reaches the block through a flat register port. It has a byte address, a write strobe and a combinational read path. The counter advances only on cycles where the tick enable is high, so any slower time base is produced outside the block.

Top module: `match_timer`

## Requirements
- R1: After reset the counter, the four compare values, the event register, the interrupt enable and the watchdog arm bit all read as zero, and `irq` and `wdog_rst` are low.
- R2: On each clock where `tick` is 1 and the count register is not being written, the counter increases by one, wrapping from all ones to zero. When `tick` is 0 the counter holds.
- R3: When a tick moves the counter onto the compare value of channel i and enable bit i is 1, event bit i is set by that same clock edge and `irq[i]` is high from that edge on.
- R4: When enable bit i is 0, a hit on channel i leaves event bit i and `irq[i]` at 0.
- R5: A write to the event register (0x14) clears each event bit i, and drops `irq[i]`, where data bit i is 1. Bits written as 0 are left unchanged. If a hit and a clear of the same bit fall on one clock, the bit ends up set.
- R6: A write to the count register (0x10) loads the written value. Counting continues from it on later ticks. A load takes priority over a tick on the same clock and never counts as a hit.
- R7: The interrupt enable register (0x1C) stores only data bits 11:0 and reads bits 31:12 as zero. Bits 3:0 enable channels 0 to 3.
- R8: Bit 0 of the watchdog register (0x18) arms the watchdog. Writing 1 sets it, writing 0 has no effect, and only reset clears it.
- R9: While the watchdog is armed, a channel 3 hit raises `wdog_rst` whatever enable bit 3 holds. `wdog_rst` stays high until reset. An unarmed channel 3 hit leaves it low.
- R10: A hit is detected once, on the tick that reaches the compare value. If the counter then rests on that value, a cleared event bit stays clear.
- R11: Compare value i sits at byte address 4*i (0x00 to 0x0C) and reads back as written. Every other address reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counting enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (8) | Byte address of the register |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data for `addr`, combinational |
| irq | output | 4 | Per-channel interrupt lines |
| wdog_rst | output | 1 | Sticky reset request from the watchdog |

## Verification
A wrong counter or compare value shows up as a missing or misplaced event. An interrupt rises one tick early or late, or never, and the count read back differs from the number of ticks applied straight after the edge. Wrong event-register handling shows on `irq` in the clock after the offending write or tick. A watchdog arm bit that is lost or set falsely changes `wdog_rst` on the first channel 3 hit that follows. So every check samples just after the edge where the hit, load or clear happens.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int IEN_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [3:0]    irq,
  output logic          wdog_rst
);
  localparam logic [AW-1:0] A_CNT = AW'(8'h10);
  localparam logic [AW-1:0] A_EVT = AW'(8'h14);
  localparam logic [AW-1:0] A_WDG = AW'(8'h18);
  localparam logic [AW-1:0] A_IEN = AW'(8'h1C);

  logic [DW-1:0]    cnt;
  logic [DW-1:0]    cmp [4];
  logic [3:0]       evt;
  logic [IEN_W-1:0] ien;
  logic             wdg_arm;
  logic [3:0]       hit;

  wire           ld_cnt = wr_en && addr == A_CNT;
  wire           adv    = tick && !ld_cnt;
  wire [DW-1:0]  nxt    = cnt + 1'b1;
  wire [3:0]     clr    = (wr_en && addr == A_EVT) ? wdata[3:0] : 4'b0;

  for (genvar i = 0; i < 4; i++) begin : g_ch
    assign hit[i] = adv && nxt == cmp[i];
    always_ff @(posedge clk)
      if (!rst_n) cmp[i] <= '0;
      else if (wr_en && addr == AW'(4 * i)) cmp[i] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      evt      <= '0;
      ien      <= '0;
      wdg_arm  <= 1'b0;
      wdog_rst <= 1'b0;
    end else begin
      if (ld_cnt) cnt <= wdata;
      else if (tick) cnt <= nxt;
      evt <= (evt & ~clr) | (hit & ien[3:0]);
      if (wr_en && addr == A_IEN) ien <= wdata[IEN_W-1:0];
      if (wr_en && addr == A_WDG && wdata[0]) wdg_arm <= 1'b1;
      if (wdg_arm && hit[3]) wdog_rst <= 1'b1;
    end
  end

  assign irq = evt;

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(8'h00): rdata = cmp[0];
      AW'(8'h04): rdata = cmp[1];
      AW'(8'h08): rdata = cmp[2];
      AW'(8'h0C): rdata = cmp[3];
      A_CNT:      rdata = cnt;
      A_EVT:      rdata = DW'(evt);
      A_WDG:      rdata = DW'(wdg_arm);
      A_IEN:      rdata = DW'(ien);
      default:    rdata = '0;
    endcase
  end

  // R2: a plain tick advances the count by one
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ld_cnt |=> cnt == $past(cnt) + 1'b1);

  // R6: a load takes the written value
  a_r6_count_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cnt |=> cnt == $past(wdata));

  // R4: an event bit only appears on an enabled channel
  a_r4_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~$past(irq) & ~$past(ien[3:0])) == 4'b0));

  // R8: the watchdog arm bit never drops
  a_r8_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_arm |=> wdg_arm);

  // R9: the reset request is sticky and needs an armed watchdog and a channel 3 hit
  a_r9_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> wdog_rst);
  a_r9_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_rst) |-> $past(wdg_arm) && cnt == cmp[3]);
endmodule

// File: tb/match_timer_bench.sv
`timescale 1ns/1ps
module match_timer_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick = 0;
  logic        wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  logic        wdog_rst;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  match_timer u_match_timer (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wdog_rst(wdog_rst));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #0.5 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1;
    end
    @(negedge clk); tick = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 32; a += 4) begin
      rd(8'(a), d); check("R1 reg", d, 0);
    end
    check("R1 irq", 32'(irq), 0);
    check("R1 wdog", 32'(wdog_rst), 0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    wr(8'h10, 100); ticks(5); rd(8'h10, d); check("R2/R6 count", d, 105);
    repeat (3) @(negedge clk); rd(8'h10, d); check("R2 hold", d, 105);
    wr(8'h10, 32'hFFFF_FFFF); ticks(1); rd(8'h10, d); check("R2 wrap", d, 0);
  endtask

  task automatic t_match;
    logic [31:0] d;
    wr(8'h00, 20); wr(8'h1C, 1); wr(8'h10, 15);
    ticks(4); check("R3 early", 32'(irq), 0);
    ticks(1); check("R3 irq", 32'(irq), 1);
    rd(8'h14, d); check("R3 evt", d, 1);
    wr(8'h14, 0); rd(8'h14, d); check("R5 zero keeps", d, 1);
    wr(8'h14, 1); check("R5 clear irq", 32'(irq), 0);
    repeat (4) @(negedge clk);
    rd(8'h14, d); check("R10 once", d, 0);
    wr(8'h10, 20); ticks(0); rd(8'h14, d); check("R6 load no hit", d, 0);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    wr(8'h04, 30); wr(8'h10, 25); ticks(5);
    rd(8'h14, d); check("R4 disabled", d, 0);
    check("R4 irq", 32'(irq), 0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    wr(8'h10, 19); wr(8'h14, 1);
    @(negedge clk); tick = 1; wr_en = 1; addr = 8'h14; wdata = 1;
    @(negedge clk); tick = 0; wr_en = 0;
    rd(8'h14, d); check("R5 set wins", d, 1);
    wr(8'h14, 32'hF);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, d); check("R7 mask", d, 32'hFFF);
    wr(8'h1C, 1);
    wr(8'h08, 32'hA5A5_0001); rd(8'h08, d); check("R11 cmp2", d, 32'hA5A5_0001);
    wr(8'h20, 32'h1234); rd(8'h20, d); check("R11 unmapped", d, 0);
  endtask

  task automatic t_wdog;
    logic [31:0] d;
    wr(8'h0C, 50); wr(8'h10, 48); ticks(2);
    check("R9 unarmed", 32'(wdog_rst), 0);
    wr(8'h18, 1); wr(8'h18, 0); rd(8'h18, d); check("R8 sticky", d, 1);
    wr(8'h10, 48); ticks(1); check("R9 early", 32'(wdog_rst), 0);
    ticks(1); check("R9 fire", 32'(wdog_rst), 1);
    ticks(3); check("R9 held", 32'(wdog_rst), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_count();
    t_match();
    t_disabled();
    t_race();
    t_regs();
    t_wdog();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule